// File: doc/BRIEF.md
# Streaming Vertical Max-Pool Stage

This block is the second half of a separable max-pooling engine. It takes a stream of words that a horizontal stage has already reduced. Each word holds eight signed 16-bit channel lanes. The block folds every non-overlapping window of `Ky` consecutive rows into one row of outputs. Partial maxima wait in an on-chip row buffer, with one 128-bit entry per output column. Each accepted word costs one buffer read, one lane-wise merge and either one write-back or one output beat.

A frame is a set of channel tiles. Each tile is a grid of input rows by output columns, sent tile by tile, row by row and column by column. Software pulses `start` with the geometry for the frame. The block then accepts exactly `tiles x in_rows x out_cols` words on a valid/ready input. On a valid/ready output it sends one word per column after the last row of each window. The final beat of the frame carries a last flag. Output backpressure stalls the pipeline without losing any word, and with no backpressure the block sustains one word per clock.

Top module: `vpool_stream`

## Requirements
- R1: After reset, `out_valid` and `in_ready` are both low.
- R2: One cycle after a `start` pulse, `in_ready` is high. Once the last input word of the frame (`tiles x in_rows x out_cols` words) has been accepted, `in_ready` stays low until the next `start`.
- R3: Lane k of a word sits at bits 16k+15 down to 16k, as two's-complement signed. Each output lane is the signed maximum of that lane, over one column, across the rows of one window.
- R4: On a row whose index within its tile, modulo `cfg_win_rows`, is zero, the incoming word starts a new window. Whatever the row buffer held before, from earlier windows, tiles or frames, has no effect on the result.
- R5: An output word for each column is produced, in column order, only after a row whose index plus one is a multiple of `cfg_win_rows`. Rows that do not close a window produce no output.
- R6: Row counting restarts at every tile, so windows never span two tiles.
- R7: When `cfg_in_rows` is not a multiple of `cfg_win_rows`, the rows of the incomplete final window of each tile produce no output.
- R8: `out_last` is high on output beat number `tiles x cfg_out_rows x out_cols - 1` (counting from 0 after `start`) and low on every other beat. `cfg_out_rows` is the number of complete windows per tile.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold steady and no word is lost or duplicated.
- R10: With `out_ready` held high and input words always offered, `in_ready` stays high for the whole frame (one word per clock).
- R11: With a single output column, consecutive words hit the same buffer entry in back-to-back cycles and the results are still correct.
- R12: With a window height of 1, every input word leaves unchanged as an output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: capture geometry and begin a frame |
| cfg_tiles | input | 16 | Number of channel tiles in the frame (nonzero) |
| cfg_in_rows | input | 16 | Input rows per tile (nonzero) |
| cfg_out_cols | input | 16 | Columns per row, at most the buffer depth (nonzero) |
| cfg_win_rows | input | 16 | Window height in rows (nonzero) |
| cfg_out_rows | input | 16 | Complete windows per tile, used for the last flag |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word taken when high with `in_valid` |
| in_data | input | 128 | Eight signed 16-bit lanes |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 128 | Eight pooled signed 16-bit lanes |
| out_last | output | 1 | Final beat of the frame |

## Verification
A wrong buffer entry or a missed write-back shows up as a wrong lane value on the next output of that column, within one window of rows. A slip in the row phase moves an output burst to the wrong row, or creates or drops one, and the per-beat comparison reports it at the first misplaced beat. A forwarding fault on back-to-back accesses to the same address appears only with a single column, and it corrupts the first window that merges two rows. A beat-counter fault shows as `out_last` on the wrong beat or missing at the end of the frame.

// File: rtl/vpool_pkg.sv
package vpool_pkg;
    localparam int LANES     = 8;
    localparam int LANE_W    = 16;
    localparam int WORD_W    = LANES * LANE_W;
    localparam int ROW_DEPTH = 512;
    localparam int ADDR_W    = $clog2(ROW_DEPTH);
    localparam int CFG_W     = 16;
    localparam int TOT_W     = 3 * CFG_W;

    typedef logic [WORD_W-1:0] word_t;

    // Beat held between buffer read and merge
    typedef struct packed {
        word_t             data;
        logic              first;
        logic              emit;
        logic [ADDR_W-1:0] col;
    } beat_t;

    function automatic logic [LANE_W-1:0] smax(input logic [LANE_W-1:0] a,
                                               input logic [LANE_W-1:0] b);
        return ($signed(a) > $signed(b)) ? a : b;
    endfunction
endpackage

// File: rtl/vpool_rowbuf.sv
module vpool_rowbuf #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        if (rd_en) rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/vpool_merge.sv
module vpool_merge
    import vpool_pkg::*;
(
    input  word_t prev,
    input  word_t inc,
    input  logic  first,
    output word_t res
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign res[k*LANE_W +: LANE_W] = first ? inc[k*LANE_W +: LANE_W]
                                               : smax(prev[k*LANE_W +: LANE_W], inc[k*LANE_W +: LANE_W]);
    end
endmodule

// File: rtl/vpool_walker.sv
module vpool_walker
    import vpool_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CFG_W-1:0]  cfg_tiles,
    input  logic [CFG_W-1:0]  cfg_rows,
    input  logic [CFG_W-1:0]  cfg_cols,
    input  logic [CFG_W-1:0]  cfg_win,
    input  logic              step,
    output logic              busy,
    output logic [ADDR_W-1:0] col,
    output logic              first,
    output logic              emit
);
    logic [CFG_W-1:0] tiles_r, rows_r, cols_r, win_r;
    logic [CFG_W-1:0] col_c, row_c, tile_c, ph_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            col_c  <= '0;
            row_c  <= '0;
            tile_c <= '0;
            ph_c   <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            tiles_r <= cfg_tiles;
            rows_r  <= cfg_rows;
            cols_r  <= cfg_cols;
            win_r   <= cfg_win;
            col_c   <= '0;
            row_c   <= '0;
            tile_c  <= '0;
            ph_c    <= '0;
        end else if (step && busy) begin
            if (col_c == cols_r - 1'b1) begin
                col_c <= '0;
                if (row_c == rows_r - 1'b1) begin
                    row_c <= '0;
                    ph_c  <= '0;
                    if (tile_c == tiles_r - 1'b1) begin
                        tile_c <= '0;
                        busy   <= 1'b0;
                    end else begin
                        tile_c <= tile_c + 1'b1;
                    end
                end else begin
                    row_c <= row_c + 1'b1;
                    ph_c  <= (ph_c == win_r - 1'b1) ? '0 : ph_c + 1'b1;
                end
            end else begin
                col_c <= col_c + 1'b1;
            end
        end
    end

    assign col   = col_c[ADDR_W-1:0];
    assign first = (ph_c == '0);
    assign emit  = (ph_c == win_r - 1'b1);

    AST_COL_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (col_c < cols_r)); // R5
    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ph_c < win_r)); // R6
endmodule

// File: rtl/vpool_stream.sv
module vpool_stream
    import vpool_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CFG_W-1:0]  cfg_tiles,
    input  logic [CFG_W-1:0]  cfg_in_rows,
    input  logic [CFG_W-1:0]  cfg_out_cols,
    input  logic [CFG_W-1:0]  cfg_win_rows,
    input  logic [CFG_W-1:0]  cfg_out_rows,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last
);
    logic              busy, w_first, w_emit;
    logic [ADDR_W-1:0] w_col;
    logic              accept, s1_go, adv1, wr_en;
    logic              s1_valid;
    beat_t             s1;
    word_t             rd_data, prev, res, byp_data;
    logic              byp_hit;
    logic [TOT_W-1:0]  beat_cnt, total_r;

    assign s1_go    = !s1.emit || !out_valid || out_ready;
    assign adv1     = s1_valid && s1_go;
    assign in_ready = busy && (!s1_valid || s1_go);
    assign accept   = in_valid && in_ready;
    assign wr_en    = adv1 && !s1.emit;
    assign prev     = byp_hit ? byp_data : rd_data;

    vpool_walker i_walker (
        .clk(clk), .rst(rst), .start(start),
        .cfg_tiles(cfg_tiles), .cfg_rows(cfg_in_rows),
        .cfg_cols(cfg_out_cols), .cfg_win(cfg_win_rows),
        .step(accept), .busy(busy), .col(w_col),
        .first(w_first), .emit(w_emit)
    );

    vpool_rowbuf #(.DEPTH(ROW_DEPTH), .WIDTH(WORD_W)) i_rowbuf (
        .clk(clk), .rd_en(accept), .rd_addr(w_col), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(s1.col), .wr_data(res)
    );

    vpool_merge i_merge (.prev(prev), .inc(s1.data), .first(s1.first), .res(res));

    // Stage 1 register and same-address forwarding
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1       <= '0;
            byp_hit  <= 1'b0;
            byp_data <= '0;
        end else begin
            if (accept) begin
                s1_valid <= 1'b1;
                s1       <= '{data: in_data, first: w_first, emit: w_emit, col: w_col};
                byp_hit  <= wr_en && (s1.col == w_col);
                byp_data <= res;
            end else if (adv1) begin
                s1_valid <= 1'b0;
            end
        end
    end

    // Output register and beat counter
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
            beat_cnt  <= '0;
            total_r   <= '0;
        end else begin
            if (start) begin
                beat_cnt <= '0;
                total_r  <= TOT_W'(cfg_tiles) * TOT_W'(cfg_out_rows) * TOT_W'(cfg_out_cols);
            end else if (adv1 && s1.emit) begin
                beat_cnt <= beat_cnt + 1'b1;
            end
            if (adv1 && s1.emit) begin
                out_valid <= 1'b1;
                out_data  <= res;
                out_last  <= (beat_cnt == total_r - 1'b1);
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R9
    AST_LAST_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last && !start) |=> !(out_valid && out_last)); // R8
    AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (beat_cnt <= total_r)); // R8
    AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && s1_valid && s1.emit) |-> !in_ready); // R9
endmodule

// File: tb/test_vpool_stream.sv
module test_vpool_stream;
    localparam int W = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [15:0]   cfg_tiles = '0, cfg_in_rows = '0, cfg_out_cols = '0, cfg_win_rows = '0, cfg_out_rows = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [W-1:0]  in_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [W-1:0]  out_data;
    logic          out_last;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vpool_stream i_vpool_stream (
        .clk(clk), .rst(rst), .start(start),
        .cfg_tiles(cfg_tiles), .cfg_in_rows(cfg_in_rows), .cfg_out_cols(cfg_out_cols),
        .cfg_win_rows(cfg_win_rows), .cfg_out_rows(cfg_out_rows),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    logic [W-1:0] mbuf [512];
    logic [W-1:0] exp_data [$];
    bit           exp_last [$];

    function automatic logic [W-1:0] lane_max(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] r;
        for (int k = 0; k < 8; k++) begin
            int va = $signed(a[k*16 +: 16]);
            int vb = $signed(b[k*16 +: 16]);
            r[k*16 +: 16] = (va > vb) ? a[k*16 +: 16] : b[k*16 +: 16];
        end
        return r;
    endfunction

    function automatic logic [W-1:0] rand_word();
        logic [W-1:0] r;
        for (int q = 0; q < 4; q++) r[q*32 +: 32] = $urandom;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_frame(input int tiles, input int rows, input int cols, input int ky,
                             input int in_rate, input int out_rate, input string tag);
        int n_in = tiles * rows * cols;
        int total = tiles * (rows / ky) * cols;
        int sent = 0, pushed = 0, popped = 0;
        int col = 0, row = 0;
        bit taken = 1'b0;
        bit stall_seen = 1'b0;
        int guard = 0;
        @(negedge clk);
        in_valid = 1'b0;
        cfg_tiles = 16'(tiles); cfg_in_rows = 16'(rows); cfg_out_cols = 16'(cols);
        cfg_win_rows = 16'(ky); cfg_out_rows = 16'(rows / ky);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        check(in_ready === 1'b1, "R2 ready after start", {127'b0, in_ready}, 128'd1);
        while ((sent < n_in || exp_data.size() != 0) && guard < 20000) begin
            guard++;
            if (guard > 1) @(negedge clk);
            if (taken) begin in_valid = 1'b0; taken = 1'b0; end
            if (!in_valid && sent < n_in && ($urandom % 100) < in_rate) begin
                in_valid = 1'b1;
                in_data = rand_word();
            end
            out_ready = (($urandom % 100) < out_rate);
            #1;
            if (out_valid && out_ready) begin
                if (exp_data.size() == 0) begin
                    check(1'b0, "R5 extra output", out_data, '0);
                end else begin
                    logic [W-1:0] e = exp_data.pop_front();
                    bit el = exp_last.pop_front();
                    check(out_data === e, tag, out_data, e);
                    check(out_last === el, "R8 last flag", {127'b0, out_last}, {127'b0, el});
                    popped++;
                end
            end
            if (in_valid && in_rate == 100 && out_rate == 100 && !in_ready) stall_seen = 1'b1;
            if (in_valid && in_ready) begin
                logic [W-1:0] v;
                int ph = row % ky;
                v = (ph == 0) ? in_data : lane_max(mbuf[col], in_data);
                if (ph == ky - 1 && row < (rows / ky) * ky) begin
                    exp_data.push_back(v);
                    exp_last.push_back(pushed == total - 1);
                    pushed++;
                end else begin
                    mbuf[col] = v;
                end
                sent++;
                taken = 1'b1;
                col++;
                if (col == cols) begin
                    col = 0;
                    row++;
                    if (row == rows) row = 0;
                end
            end
        end
        @(negedge clk);
        if (taken) in_valid = 1'b0;
        out_ready = 1'b1;
        #1;
        check(popped == total, "R5 output count", 128'(popped), 128'(total));
        check(in_ready === 1'b0, "R2 ready low after frame", {127'b0, in_ready}, 128'd0);
        check(out_valid === 1'b0, "R5 no stray output", {127'b0, out_valid}, 128'd0);
        if (in_rate == 100 && out_rate == 100)
            check(!stall_seen, "R10 full rate", {127'b0, stall_seen}, 128'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(out_valid === 1'b0, "R1 out_valid reset", {127'b0, out_valid}, 128'd0);
        check(in_ready === 1'b0, "R1 in_ready reset", {127'b0, in_ready}, 128'd0);
        run_frame(2, 4, 3, 2, 100, 100, "R3 R6 two tiles");
        run_frame(1, 6, 4, 3, 70, 60, "R9 backpressure");
        run_frame(3, 4, 1, 4, 100, 100, "R11 single column");
        run_frame(2, 4, 1, 2, 80, 50, "R11 single column stalled");
        run_frame(1, 2, 5, 1, 100, 100, "R12 window of one");
        run_frame(2, 5, 2, 2, 90, 70, "R4 R7 partial window");
        run_frame(2, 9, 7, 3, 100, 40, "R3 R4 mixed");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule